// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits after an instruction fetch buffer. It takes a stream of 16-bit halfwords, one per accepted cycle. The leading halfword of each instruction carries a prefix in its upper bits. The block reads that prefix to learn the instruction's length and class. It then collects the remaining halfwords and places them in an 80-bit word in the bit order that the class requires. Each completed instruction leaves the block on its own, together with a class code and a length in halfwords. Fetch addressing, branch redirection and opcode field decoding belong to other blocks.

Both sides use a valid/ready handshake. On the input side, a halfword moves when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` drops while a finished instruction waits to be taken, and it also drops during a flush. On the output side, `out_valid` stays high until the cycle in which `out_ready` is high. While it waits, the word, class and length do not change. A back-pressured output therefore stalls the input after exactly one instruction.

Each bit of the `CLASS_EN` parameter allows one class. A leading halfword whose class is not allowed is reported as invalid and uses up only itself. The halfword after it is then treated as a new leading halfword.

Top module: `insn_aligner`

## Requirements
- R1: A leading halfword with bit 15 clear is a scalar16 instruction (class code 1) of length 1. It appears in `out_word[15:0]`.
- R2: A leading halfword whose bits 15:12 are 0x8 to 0xD is a scalar32 instruction (class code 2) of length 2. The leading halfword appears in bits 31:16 and the second halfword in bits 15:0.
- R3: A leading halfword whose bits 15:12 equal 0xE is a scalar48 instruction (class code 3) of length 3. The leading halfword appears in bits 47:32, the third halfword in bits 31:16 and the second halfword in bits 15:0.
- R4: A leading halfword whose bits 15:11 equal 11110 is a vector48 instruction (class code 4) of length 3. The leading halfword appears in bits 47:32, the second halfword in bits 31:16 and the third halfword in bits 15:0.
- R5: A leading halfword whose bits 15:11 equal 11111 is a vector80 instruction (class code 5) of length 5. Its five halfwords fill bits 79:64, 63:48, 47:32, 31:16 and 15:0 in the order they arrive.
- R6: Every `out_word` bit above 16 times `out_len` is zero. While `out_valid` is low, `out_word`, `out_class` and `out_len` are all zero.
- R7: `CLASS_EN` bit k-1 enables class code k. A leading halfword of a disabled class is reported as invalid (class code 0) with length 1 and the halfword in bits 15:0. The next halfword accepted is then classified as a leading halfword.
- R8: While `out_valid` is high and `out_ready` is low, `out_word`, `out_class` and `out_len` hold their values and `in_ready` stays low.
- R9: `out_valid` rises in the cycle after the last halfword of an instruction is accepted. It falls in the cycle after `out_ready` is seen high.
- R10: A synchronous `flush` discards both a partly gathered instruction and an untaken output. `in_ready` is low during the flush, and the next halfword accepted after it is treated as a leading halfword.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all gathered state |
| in_valid | input | 1 | Input halfword present |
| in_ready | output | 1 | Block can take a halfword |
| in_half | input | 16 | Halfword; bits 7:0 hold the byte at the lower address |
| out_valid | output | 1 | Assembled instruction present |
| out_ready | input | 1 | Consumer takes the instruction |
| out_word | output | 80 | Assembled instruction bits, zero-extended |
| out_class | output | 3 | 0 invalid, 1 scalar16, 2 scalar32, 3 scalar48, 4 vector48, 5 vector80 |
| out_len | output | 3 | Length in halfwords |

## Verification
The bench sweeps all 32 values of the five prefix bits, with several fillers for the low bits and the trailing halfwords. This exposes a misplaced class boundary, such as treating 0xE as scalar32 or mixing up the two 48-bit formats. A design that swapped the trailing halfwords of the wrong 48-bit format would place the second and third halfwords in each other's slots, and the word check would show it. Every instruction is also held under back-pressure. A design that kept taking halfwords, or let the word move, during the wait would break the hold checks.

A second instance with vector80 disabled shows that an invalid leading halfword uses up exactly one halfword, so the halfword after it decodes on its own. Flush is applied both in the middle of gathering and while an output is pending. A design that kept a stale count would then misread the next leading halfword as a trailing one.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int HW_W   = 16;
  localparam int MAX_HW = 5;
  localparam int WORD_W = HW_W * MAX_HW;
  localparam int LEN_W  = $clog2(MAX_HW + 1);

  typedef enum logic [2:0] {
    IC_INVALID = 3'd0,
    IC_S16     = 3'd1,
    IC_S32     = 3'd2,
    IC_S48     = 3'd3,
    IC_V48     = 3'd4,
    IC_V80     = 3'd5
  } ia_class_e;

  function automatic logic [LEN_W-1:0] class_len(input ia_class_e c);
    case (c)
      IC_S32:          return LEN_W'(2);
      IC_S48, IC_V48:  return LEN_W'(3);
      IC_V80:          return LEN_W'(5);
      default:         return LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ia_classifier.sv
module ia_classifier
  import ia_pkg::*;
#(
  parameter logic [4:0] CLASS_EN = 5'b11111
) (
  input  logic [HW_W-1:0]  lead,
  output ia_class_e        cls,
  output logic [LEN_W-1:0] len
);
  ia_class_e raw;

  always_comb begin
    if (!lead[HW_W-1])
      raw = IC_S16;
    else if (lead[HW_W-1 -: 4] <= 4'hD)
      raw = IC_S32;
    else if (lead[HW_W-1 -: 4] == 4'hE)
      raw = IC_S48;
    else if (!lead[HW_W-5])
      raw = IC_V48;
    else
      raw = IC_V80;
  end

  always_comb begin
    cls = raw;
    if (!CLASS_EN[3'(raw) - 3'd1])
      cls = IC_INVALID;
    len = class_len(cls);
  end
endmodule

// File: rtl/ia_gather.sv
module ia_gather
  import ia_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [HW_W-1:0]         in_half,
  input  ia_class_e               lead_cls,
  input  logic [LEN_W-1:0]        lead_len,
  input  logic                    out_ready,
  output logic                    full,
  output ia_class_e               cls_q,
  output logic [LEN_W-1:0]        len_q,
  output logic [MAX_HW*HW_W-1:0]  slots
);
  logic [LEN_W-1:0] cnt_q;
  logic             accept;
  logic [LEN_W-1:0] cnt_nx;

  assign in_ready = !full && !flush;
  assign accept   = in_valid && in_ready;
  assign cnt_nx   = cnt_q + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      full  <= 1'b0;
      cls_q <= IC_INVALID;
      len_q <= '0;
    end else if (flush) begin
      cnt_q <= '0;
      full  <= 1'b0;
    end else if (full) begin
      if (out_ready) begin
        full  <= 1'b0;
        cnt_q <= '0;
      end
    end else if (accept) begin
      cnt_q <= cnt_nx;
      if (cnt_q == '0) begin
        cls_q <= lead_cls;
        len_q <= lead_len;
        full  <= (lead_len == LEN_W'(1));
      end else begin
        full  <= (cnt_nx == len_q);
      end
    end
  end

  for (genvar i = 0; i < MAX_HW; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[i*HW_W +: HW_W] <= '0;
      else if (accept && cnt_q == LEN_W'(i))
        slots[i*HW_W +: HW_W] <= in_half;
    end
  end
endmodule

// File: rtl/ia_packer.sv
module ia_packer
  import ia_pkg::*;
(
  input  logic                    valid,
  input  ia_class_e               cls,
  input  logic [MAX_HW*HW_W-1:0]  slots,
  output logic [WORD_W-1:0]       word
);
  logic [HW_W-1:0] h [MAX_HW];

  for (genvar i = 0; i < MAX_HW; i++) begin : g_split
    assign h[i] = slots[i*HW_W +: HW_W];
  end

  always_comb begin
    word = '0;
    if (valid) begin
      case (cls)
        IC_S32:  word[2*HW_W-1:0] = {h[0], h[1]};
        IC_S48:  word[3*HW_W-1:0] = {h[0], h[2], h[1]};
        IC_V48:  word[3*HW_W-1:0] = {h[0], h[1], h[2]};
        IC_V80:  word = {h[0], h[1], h[2], h[3], h[4]};
        default: word[HW_W-1:0] = h[0];
      endcase
    end
  end
endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
  import ia_pkg::*;
#(
  parameter logic [4:0] CLASS_EN = 5'b11111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [15:0]  in_half,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [79:0]  out_word,
  output logic [2:0]   out_class,
  output logic [2:0]   out_len
);
  ia_class_e               lead_cls;
  logic [LEN_W-1:0]        lead_len;
  ia_class_e               cls_q;
  logic [LEN_W-1:0]        len_q;
  logic [MAX_HW*HW_W-1:0]  slots;
  logic                    full;

  ia_classifier #(.CLASS_EN(CLASS_EN)) u_cls (
    .lead (in_half),
    .cls  (lead_cls),
    .len  (lead_len)
  );

  ia_gather u_gat (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_half   (in_half),
    .lead_cls  (lead_cls),
    .lead_len  (lead_len),
    .out_ready (out_ready),
    .full      (full),
    .cls_q     (cls_q),
    .len_q     (len_q),
    .slots     (slots)
  );

  ia_packer u_pak (
    .valid (full),
    .cls   (cls_q),
    .slots (slots),
    .word  (out_word)
  );

  assign out_valid = full;
  assign out_class = full ? 3'(cls_q) : 3'd0;
  assign out_len   = full ? 3'(len_q) : 3'd0;
endmodule

// File: rtl/ia_checker.sv
module ia_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [79:0] out_word,
  input logic [2:0]  out_class,
  input logic [2:0]  out_len
);
  assert_s16_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd1) |-> !out_word[15]);

  assert_upper_zero_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 3'd1) |-> out_word[79:16] == '0);

  assert_upper_zero_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 3'd3) |-> out_word[79:48] == '0);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0 && out_class == 3'd0 && out_len == 3'd0));

  assert_invalid_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd0) |-> out_len == 3'd1);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_word) && $stable(out_class) && $stable(out_len)));

  assert_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_valid_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

bind insn_aligner ia_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_class (out_class),
  .out_len   (out_len)
);

// File: tb/insn_aligner_tb.sv
`timescale 1ns/1ps
module insn_aligner_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic out_ready = 1'b0;
  logic sel = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic ir0, ov0, ir1, ov1;
  logic [79:0] w0, w1;
  logic [2:0] c0, c1, l0, l1;

  always #4 clk = ~clk;

  insn_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(ir0),
    .in_half(in_half), .out_valid(ov0), .out_ready(out_ready),
    .out_word(w0), .out_class(c0), .out_len(l0));

  insn_aligner #(.CLASS_EN(5'b01111)) u_dut_nov80 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(ir1),
    .in_half(in_half), .out_valid(ov1), .out_ready(out_ready),
    .out_word(w1), .out_class(c1), .out_len(l1));

  logic        s_ir, s_ov;
  logic [79:0] s_w;
  logic [2:0]  s_c, s_l;
  assign s_ir = sel ? ir1 : ir0;
  assign s_ov = sel ? ov1 : ov0;
  assign s_w  = sel ? w1 : w0;
  assign s_c  = sel ? c1 : c0;
  assign s_l  = sel ? l1 : l0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] h0, h1, h2, h3, h4, input logic [4:0] en,
                                output logic [79:0] w, output logic [2:0] c, output logic [2:0] n);
    if (!h0[15]) c = 3'd1;
    else if (h0[15:12] <= 4'hD) c = 3'd2;
    else if (h0[15:12] == 4'hE) c = 3'd3;
    else if (!h0[11]) c = 3'd4;
    else c = 3'd5;
    if (!en[c - 3'd1]) c = 3'd0;
    case (c)
      3'd2: begin n = 2; w = (80'(h0) << 16) | 80'(h1); end
      3'd3: begin n = 3; w = (80'(h0) << 32) | (80'(h2) << 16) | 80'(h1); end
      3'd4: begin n = 3; w = (80'(h0) << 32) | (80'(h1) << 16) | 80'(h2); end
      3'd5: begin n = 5; w = (80'(h0) << 64) | (80'(h1) << 48) | (80'(h2) << 32) | (80'(h3) << 16) | 80'(h4); end
      default: begin n = 1; w = 80'(h0); end
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic push(input logic [15:0] h);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    while (!s_ir) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_one(input logic [15:0] h0, h1, h2, h3, h4, input logic [4:0] en);
    logic [79:0] ew, held;
    logic [2:0] ec, el;
    logic [15:0] hs [5];
    model(h0, h1, h2, h3, h4, en, ew, ec, el);
    hs[0] = h0; hs[1] = h1; hs[2] = h2; hs[3] = h3; hs[4] = h4;
    for (int i = 0; i < int'(el); i++) begin
      if (i == int'(el) - 1) begin
        @(negedge clk);
        chk(!s_ov, "R9 not early", 80'(s_ov), 80'(0));
      end
      push(hs[i]);
    end
    @(negedge clk);
    chk(s_ov == 1'b1, "R9 valid after last", 80'(s_ov), 80'(1));
    chk(s_w == ew, req_of(ec), s_w, ew);
    chk(s_c == ec && s_l == el, {req_of(ec), " class/len"}, 80'({s_c, s_l}), 80'({ec, el}));
    chk((s_w >> (16 * int'(el))) == '0, "R6 upper zero", s_w, ew);
    held = s_w;
    @(negedge clk);
    chk(s_ov && s_w == held && !s_ir, "R8 hold", s_w, held);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    chk(!s_ov && s_w == '0, "R9 drop after take / R6 idle", s_w, 80'(0));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1 chk(!s_ir, "R10 in_ready low in flush", 80'(s_ir), 80'(0));
    @(posedge clk);
    #1 flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!ov0 && ir0 && w0 == '0, "R11 reset", {w0[77:0], ov0, ir0}, 80'(1));

    // Sweep every 5-bit prefix on the fully enabled instance
    sel = 1'b0;
    do_flush();
    for (int t = 0; t < 32; t++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] a, b, c, d, e;
        a = {5'(t), 11'(k * 397 + t * 13)};
        b = 16'(t * 4099 + k * 257 + 16'h1111);
        c = 16'(t * 4099 + k * 257 + 16'h2222);
        d = 16'(t * 4099 + k * 257 + 16'h3333);
        e = 16'(t * 4099 + k * 257 + 16'h4444);
        run_one(a, b, c, d, e, 5'b11111);
      end
    end

    // R10: flush mid-gather, then a lone scalar16 must decode alone
    push(16'hE123);
    push(16'hBEEF);
    do_flush();
    run_one(16'h0042, 16'h0, 16'h0, 16'h0, 16'h0, 5'b11111);
    // R10: flush with an untaken output pending
    push(16'h0007);
    @(negedge clk);
    chk(ov0, "R10 pending before flush", 80'(ov0), 80'(1));
    do_flush();
    @(negedge clk);
    chk(!ov0 && ir0, "R10 pending discarded", 80'(ov0), 80'(0));
    run_one(16'h8123, 16'h4567, 16'h0, 16'h0, 16'h0, 5'b11111);

    // R7: instance with vector80 disabled
    sel = 1'b1;
    do_flush();
    run_one(16'hF955, 16'h0, 16'h0, 16'h0, 16'h0, 5'b01111);
    run_one(16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 5'b01111);
    run_one(16'hF8AA, 16'h0, 16'h0, 16'h0, 16'h0, 5'b01111);
    run_one(16'hF8BB, 16'hCAFE, 16'hD00D, 16'h0, 16'h0, 5'b01111);
    for (int t = 0; t < 32; t++) begin
      run_one({5'(t), 11'(t * 77)}, 16'(t * 9 + 1), 16'(t * 9 + 2), 16'(t * 9 + 3), 16'(t * 9 + 4), 5'b01111);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule